// File: doc/BRIEF.md
# ADC Result Register Bank with Completion and Overrun Flags

This block stores conversion results from a successive-approximation converter. There are eight per-channel result registers and one global register that always holds the latest result from any channel. Each completion strobe brings a channel index and a 10-bit code. The block writes that code into the channel's register and into the global register, and sets the done flag in both.

Reading a register over the simple read port returns a 32-bit word. The read also clears the done flag and the overrun flag of the register that was read, at the next clock edge. An overrun is recorded when burst mode is active and a result is overwritten before it was read.

An interrupt request is formed in one of two ways, chosen by a mode bit. In global mode it follows the global done flag. In per-channel mode it is the OR of the per-channel done flags, each gated by its bit in an enable mask.

Top module: `adc_result_bank`

## Requirements
- R1: The read word places the result code in bits 15:6, the overrun flag in bit 30 and the done flag in bit 31. Bits 29:16 and 5:0 read as zero. rd_sel values 0..7 select the channel registers, 8 selects the global register, and 9..15 read as all zeros. A result code of 0 stands for an input at or near ground, and 0x3FF for an input at or above the reference.
- R2: The clock edge that samples cmp_valid high stores cmp_value into channel cmp_chan and into the global register, and sets both done flags. The codes 0 and 0x3FF are stored exactly.
- R3: A read returns the pre-clear word combinationally. At the next edge it clears the done and overrun flags of the register that was read, and of no other register.
- R4: With burst_mode high, a completion into a register whose done flag is still set sets that register's overrun flag. Overrun then stays set until that register is read.
- R5: With burst_mode low, a completion never sets an overrun flag.
- R6: If a read and a completion hit the same register in the same cycle, the new result is kept with done = 1 and overrun = 0.
- R7: With the mode bit at 0, irq equals the OR over all channels of (done AND mask bit).
- R8: With the mode bit at 1, irq equals the global done flag, whatever the channel flags are.
- R9: Reset clears all results and flags, sets the mask to 0x01 and sets the mode bit to 1.
- R10: mask_wr loads mask_din and mode_wr loads mode_din at the clock edge. The two writes are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Conversion-complete strobe |
| cmp_chan | input | 3 | Channel index of the completed conversion |
| cmp_value | input | 10 | Conversion result code |
| burst_mode | input | 1 | High while the converter runs in burst mode (enables overrun detection) |
| rd_en | input | 1 | Read strobe (clears the flags of the selected register) |
| rd_sel | input | 4 | Register select: 0..7 channel, 8 global |
| rd_data | output | 32 | Selected register word |
| mask_wr | input | 1 | Load the interrupt enable mask |
| mask_din | input | 8 | New interrupt enable mask |
| mode_wr | input | 1 | Load the interrupt mode bit |
| mode_din | input | 1 | New mode bit (1 = global done drives irq) |
| irq | output | 1 | Interrupt request |

## Verification
A read that clears flags and a completion that sets them can land on the same register in the same cycle. This case decides both the returned word and the overrun state. The bench provokes it by driving a completion for a channel together with a read of that channel. It checks two things: that the read returns the older word, and that a follow-up read shows the new code with done set and overrun clear. The same collision is also driven on the global register through a completion on a different channel, so that one register is hit by the read and the other is not.

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  parameter int LSB   = 6,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmp_valid,
  input  logic [$clog2(NCH)-1:0]   cmp_chan,
  input  logic [RES_W-1:0]         cmp_value,
  input  logic                     burst_mode,
  input  logic                     rd_en,
  input  logic [$clog2(NCH+1)-1:0] rd_sel,
  output logic [DW-1:0]            rd_data,
  input  logic                     mask_wr,
  input  logic [NCH-1:0]           mask_din,
  input  logic                     mode_wr,
  input  logic                     mode_din,
  output logic                     irq
);
  localparam int CW   = $clog2(NCH);
  localparam int SW   = $clog2(NCH+1);
  localparam int PADW = DW - 2 - RES_W - LSB;

  logic [RES_W-1:0] res_q [NCH+1];
  logic [NCH:0]     done_q, ovr_q;
  logic [NCH-1:0]   mask_q;
  logic             gmode_q;

  for (genvar g = 0; g <= NCH; g++) begin : g_reg
    logic wr_hit, rd_hit;
    if (g == NCH) begin : g_glob
      assign wr_hit = cmp_valid;
    end else begin : g_chan
      assign wr_hit = cmp_valid && (cmp_chan == CW'(g));
    end
    assign rd_hit = rd_en && (rd_sel == SW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q[g]  <= '0;
        done_q[g] <= 1'b0;
        ovr_q[g]  <= 1'b0;
      end else if (wr_hit) begin
        res_q[g]  <= cmp_value;
        done_q[g] <= 1'b1;
        ovr_q[g]  <= !rd_hit && (ovr_q[g] || (burst_mode && done_q[g]));
      end else if (rd_hit) begin
        done_q[g] <= 1'b0;
        ovr_q[g]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= NCH'(1);
      gmode_q <= 1'b1;
    end else begin
      if (mask_wr) mask_q  <= mask_din;
      if (mode_wr) gmode_q <= mode_din;
    end
  end

  wire sel_ok = (rd_sel <= SW'(NCH));
  assign rd_data = sel_ok ? {done_q[rd_sel], ovr_q[rd_sel], {PADW{1'b0}}, res_q[rd_sel], {LSB{1'b0}}}
                          : '0;
  assign irq = gmode_q ? done_q[NCH] : |(mask_q & done_q[NCH-1:0]);

  // R2: completion lands in channel and global register
  assert_done_on_complete_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> done_q[$past(cmp_chan)] && done_q[NCH] &&
                  res_q[$past(cmp_chan)] == $past(cmp_value) && res_q[NCH] == $past(cmp_value));

  // R3: read without a colliding completion clears flags
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel < SW'(NCH) && !(cmp_valid && SW'(cmp_chan) == rd_sel))
      |=> !done_q[$past(rd_sel)] && !ovr_q[$past(rd_sel)]);

  // R5: no overrun outside burst mode
  assert_no_ovr_outside_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !burst_mode && !ovr_q[cmp_chan]) |=> !ovr_q[$past(cmp_chan)]);

  // R6: same-cycle read and completion keeps the new result, clean
  assert_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && rd_en && rd_sel == SW'(cmp_chan)) |=> done_q[$past(cmp_chan)] && !ovr_q[$past(cmp_chan)]);

  // R8: global mode raises irq after any completion
  assert_irq_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gmode_q && !mode_wr && cmp_valid) |=> irq);
endmodule

// File: tb/adc_result_bank_tb.sv
module adc_result_bank_tb_top;
  localparam int CLK_T = 10;

  logic clk = 0, rst_n = 0;
  logic cmp_valid = 0, burst_mode = 0, rd_en = 0, mask_wr = 0, mode_wr = 0, mode_din = 0;
  logic [2:0] cmp_chan = 0;
  logic [9:0] cmp_value = 0;
  logic [3:0] rd_sel = 0;
  logic [7:0] mask_din = 0;
  logic [31:0] rd_data;
  logic irq;

  adc_result_bank dut_i (.clk, .rst_n, .cmp_valid, .cmp_chan, .cmp_value, .burst_mode,
    .rd_en, .rd_sel, .rd_data, .mask_wr, .mask_din, .mode_wr, .mode_din, .irq);

  always #(CLK_T/2) clk = ~clk;

  int vectors = 0, miscomp = 0;
  logic [9:0] m_res [9];
  logic [8:0] m_done = 0, m_ovr = 0;
  logic [7:0] m_mask = 8'h01;
  logic       m_gm = 1;

  function automatic logic [31:0] word(int i);
    if (i > 8) return 32'h0;
    return {m_done[i], m_ovr[i], 14'b0, m_res[i], 6'b0};
  endfunction

  function automatic logic exp_irq();
    return m_gm ? m_done[8] : |(m_mask & m_done[7:0]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic hc, hg;
    @(negedge clk); #1;
    if (rd_en) chk({tag, " rd_data"}, rd_data, word(rd_sel));
    @(posedge clk);
    for (int i = 0; i < 9; i++) begin
      hc = (i == 8) ? cmp_valid : (cmp_valid && cmp_chan == i);
      hg = rd_en && rd_sel == i;
      if (hc) begin
        m_ovr[i]  = !hg && (m_ovr[i] || (burst_mode && m_done[i]));
        m_done[i] = 1'b1;
        m_res[i]  = cmp_value;
      end else if (hg) begin
        m_done[i] = 1'b0;
        m_ovr[i]  = 1'b0;
      end
    end
    if (mask_wr) m_mask = mask_din;
    if (mode_wr) m_gm = mode_din;
    #1;
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    cmp_valid = 0; rd_en = 0; mask_wr = 0; mode_wr = 0;
  endtask

  task automatic complete(int ch, int val, string tag);
    cmp_valid = 1; cmp_chan = ch[2:0]; cmp_value = val[9:0];
    tick(tag);
  endtask

  task automatic rd(int sel, string tag);
    rd_en = 1; rd_sel = sel[3:0];
    tick(tag);
  endtask

  initial begin
    #(CLK_T * 200000);
    miscomp++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) m_res[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R9 R1: reset state, all selects
    for (int s = 0; s < 16; s++) rd(s, "R9 reset");
    // R9: mode resets to global, mask to 0x01
    complete(1, 5, "R9 global default");
    rd(8, "R9 global read drops irq");
    mode_wr = 1; mode_din = 0; tick("R10 mode write");
    complete(0, 7, "R9 mask default bit0");
    rd(0, "R9"); rd(1, "R9");

    // R2 R1: sweep channels and codes, including extremes
    for (int ch = 0; ch < 8; ch++)
      for (int k = 0; k < 16; k++) begin
        int v;
        v = (k == 0) ? 0 : (k == 15) ? 1023 : (k * 73 + ch * 29) % 1024;
        complete(ch, v, "R2 store");
        rd(ch, "R2 channel word");
        rd(8, "R2 global word");
        rd(ch, "R3 cleared");
        rd(9 + (k % 7), "R1 unused select");
      end

    // R4: burst overwrite sets overrun, sticky through non-burst overwrite
    burst_mode = 1;
    complete(3, 11, "R4"); complete(3, 22, "R4 overwrite");
    burst_mode = 0;
    complete(3, 33, "R4 sticky");
    rd(4, "R3 other untouched");
    rd(3, "R4 overrun set");
    rd(3, "R3 overrun cleared");
    rd(8, "R4 global overrun");

    // R5: no overrun without burst
    complete(5, 100, "R5"); complete(5, 200, "R5 overwrite");
    rd(5, "R5 no overrun"); rd(8, "R5 global");

    // R6: collision on same register; global hit by read only
    burst_mode = 1;
    complete(2, 300, "R6");
    cmp_valid = 1; cmp_chan = 2; cmp_value = 10'd400; rd_en = 1; rd_sel = 2;
    tick("R6 collide returns old");
    rd(2, "R6 new result clean");
    cmp_valid = 1; cmp_chan = 6; cmp_value = 10'd500; rd_en = 1; rd_sel = 8;
    tick("R6 global collide");
    rd(8, "R6 global new"); rd(6, "R6 chan");
    burst_mode = 0;

    // R7 R10: mask sweep in per-channel mode
    complete(0, 1, "R7"); complete(2, 2, "R7"); complete(5, 3, "R7");
    rd(8, "R7");
    for (int m = 0; m < 256; m++) begin
      mask_wr = 1; mask_din = m[7:0]; tick("R7 mask sweep");
      tick("R7 mask hold");
    end
    mask_wr = 1; mask_din = 8'h04; tick("R10 mask write");
    rd(2, "R7 read drops irq");

    // R8: global mode ignores channel flags
    mode_wr = 1; mode_din = 1; tick("R8 mode");
    complete(7, 9, "R8 irq up");
    rd(8, "R8 global read drops irq");
    complete(4, 8, "R8"); rd(4, "R8 channel read keeps irq");
    rd(8, "R8 drop");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule